// File: doc/BRIEF.md
# Flash Operation Status Bit Generator

This block sits in the read path of a banked flash device and decides what a host read returns while an internal program or erase operation is under way. A command decoder tells it the current operation state, which bank is busy, which sectors of that bank are marked for erase and, at the moment a command sequence completes, whether the target is protected. For each host read it returns either a status byte carrying two toggle bits or the array data presented on its input. It also drives an active-low ready/busy pin.

The main toggle (bit 6) inverts on every read anywhere in the busy bank while a program or erase runs. It freezes while the erase is suspended and resumes when a program runs inside the suspension. The sector toggle (bit 2) inverts only on reads to sectors marked for erase, and it keeps inverting while the erase is suspended. The host can therefore tell which sectors are erasing by reading bit 2, and tell erasing from suspended by reading bit 6. A command aimed at protected storage produces a short busy window of fixed length, measured in clock cycles. The block then returns array data until the decoder goes idle.

Top module: `flash_status_gen`

## Requirements
- R1: `rdy_bsy_n` is 0 one clock after the effective operation becomes program, erase or program-during-suspend, and 1 one clock after it becomes idle or erase-suspended. Operation codes on `op_state` are 0 idle, 1 program, 2 erase, 3 erase-suspended, 4 program-during-suspend.
- R2: During program, erase or program-during-suspend, a read in the busy bank returns a status byte whose bit 6 is the inverse of the bit 6 returned by the previous status read that toggled it. Bits 7, 5, 4, 3, 1 and 0 are 0. The first such read after reset returns bit 6 = 0.
- R3: When the operation ends (idle) reads in that bank return array data. In erase-suspended state, bit 6 stays at its last value on every status read.
- R4: In program-during-suspend, bit 6 toggles again on each read of the busy bank.
- R5: Bit 2 inverts on each read to a sector whose bit is set in `erase_sel`, in erase and in erase-suspended states. A read to any other sector returns bit 2 unchanged. The first inversion after reset yields 1.
- R6: A read to a bank that is not busy, any read while idle, and a read in erase-suspended state to a sector not marked for erase return `rd_data` unchanged.
- R7: When `op_start` and `prot_hit` are both 1 in erase state, the block makes the bank busy for ERASE_WIN_US*CLK_MHZ cycles, with bit 6 toggling. It then returns array data and drives ready until `op_state` returns to idle.
- R8: The same applies in program state, with a window of PROG_WIN_US*CLK_MHZ cycles.
- R9: A read is launched on the clock edge at which `rd_oe` and `rd_ce` are first both high, whichever of the two rose last. Holding both high launches no further reads.
- R10: `dout` is registered at the launch edge and holds its value until the next launch. Reset clears `dout` to 0 and sets `rdy_bsy_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_state | input | 3 | Operation code from the command decoder |
| op_bank | input | BANK_W | Bank the operation runs in |
| erase_sel | input | SECTORS | Sectors of the busy bank marked for erase |
| op_start | input | 1 | Pulse on completion of the final command write |
| prot_hit | input | 1 | Target of the starting command is protected |
| rd_oe | input | 1 | Output enable strobe, active high |
| rd_ce | input | 1 | Chip enable strobe, active high |
| rd_bank | input | BANK_W | Bank of the read address |
| rd_sector | input | SEC_W | Sector of the read address within its bank |
| rd_data | input | DATA_W | Array data for the read address |
| dout | output | DATA_W | Value returned to the host |
| rdy_bsy_n | output | 1 | Ready (1) / busy (0) |

## Verification
The bench builds the block with two banks of eight sectors, CLK_MHZ=1, ERASE_WIN_US=40 and PROG_WIN_US=6. The protected-erase window is therefore 40 cycles and the protected-program window 6 cycles. At these values the bench can run the whole of each window, watch bit 6 toggle inside it and see the return to array data afterwards, without long waits. With two banks, reads to the idle bank can be checked for array data while the other bank is busy. With eight sectors, selected and unselected sectors can be mixed inside one bank.

// File: rtl/flash_status_pkg.sv
// Shared operation codes and helper predicates for the status generator.
// Assumes the command decoder presents one of the listed codes at all times.
package flash_status_pkg;

    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_PROG      = 3'd1,
        OP_ERASE     = 3'd2,
        OP_SUSP      = 3'd3,
        OP_SUSP_PROG = 3'd4
    } op_mode_t;

    localparam int MAIN_TOG_BIT = 6;
    localparam int SECT_TOG_BIT = 2;

    // True when the mode keeps the bank busy (ready/busy pin low).
    function automatic logic mode_is_busy(op_mode_t m);
        return (m == OP_PROG) || (m == OP_ERASE) || (m == OP_SUSP_PROG);
    endfunction

    // True when sector-selective toggling applies.
    function automatic logic mode_is_erase_family(op_mode_t m);
        return (m == OP_ERASE) || (m == OP_SUSP);
    endfunction

endpackage

// File: rtl/fsg_read_launch.sv
// Turns the two read strobes into a one-cycle launch pulse.
// Assumes both strobes are synchronous to clk. A read cycle starts when the
// later of the two strobes rises; holding both high launches nothing further.
module fsg_read_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_oe,
    input  logic rd_ce,
    output logic launch
);
    logic both_on;
    logic both_on_q;

    assign both_on = rd_oe & rd_ce;

    // Remember last cycle's combined strobe to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) both_on_q <= 1'b0;
        else        both_on_q <= both_on;
    end

    assign launch = both_on & ~both_on_q;

    p_single_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch);

endmodule

// File: rtl/fsg_prot_window.sv
// Protected-target busy window and lockout.
// When a program or erase starts on protected storage, this module holds a
// busy pseudo-operation for a fixed cycle count. It then reports idle until
// the decoder itself returns to idle. In all other cases it passes the
// decoder's mode and bank through unchanged.
module fsg_prot_window
    import flash_status_pkg::*;
#(
    parameter int BANK_W    = 1,
    parameter int ERASE_CYC = 10000,
    parameter int PROG_CYC  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_mode_t          op_mode,
    input  logic [BANK_W-1:0] op_bank,
    input  logic              op_start,
    input  logic              prot_hit,
    output op_mode_t          eff_mode,
    output logic [BANK_W-1:0] eff_bank
);
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic              win_act;
    logic              lock;
    logic [CNT_W-1:0]  cnt;
    op_mode_t          win_kind;
    logic [BANK_W-1:0] win_bank;
    logic              start_ok;

    assign start_ok = op_start && prot_hit &&
                      ((op_mode == OP_PROG) || (op_mode == OP_ERASE));

    // Arm, count down and release the protected window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_act  <= 1'b0;
            lock     <= 1'b0;
            cnt      <= '0;
            win_kind <= OP_PROG;
            win_bank <= '0;
        end else if (start_ok) begin
            win_act  <= 1'b1;
            lock     <= 1'b0;
            win_kind <= op_mode;
            win_bank <= op_bank;
            cnt      <= (op_mode == OP_ERASE) ? CNT_W'(ERASE_CYC - 1)
                                              : CNT_W'(PROG_CYC - 1);
        end else if (win_act) begin
            if (cnt == '0) begin
                win_act <= 1'b0;
                lock    <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (lock && (op_mode == OP_IDLE)) begin
            lock <= 1'b0;
        end
    end

    // Select the mode the rest of the block acts on.
    always_comb begin
        if (win_act) begin
            eff_mode = win_kind;
            eff_bank = win_bank;
        end else if (lock) begin
            eff_mode = OP_IDLE;
            eff_bank = op_bank;
        end else begin
            eff_mode = op_mode;
            eff_bank = op_bank;
        end
    end

    p_window_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_act && cnt == '0 && !start_ok) |=> (!win_act && lock));

    p_count_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_act |-> (cnt < CNT_W'(MAX_CYC)));

endmodule

// File: rtl/fsg_toggle_bits.sv
// Holds the two toggle bits. Each bit inverts on the cycle its flip
// request is high and otherwise keeps its value. Both reset to 0.
module fsg_toggle_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic flip_main,
    input  logic flip_sect,
    output logic t_main,
    output logic t_sect
);
    // Invert each toggle on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_main <= 1'b0;
            t_sect <= 1'b0;
        end else begin
            if (flip_main) t_main <= ~t_main;
            if (flip_sect) t_sect <= ~t_sect;
        end
    end

    p_sect_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !flip_sect |=> $stable(t_sect));

endmodule

// File: rtl/flash_status_gen.sv
// Top of the status bit generator. It decides per host read whether to
// return a status byte (main and sector toggle bits, all else zero) or the
// array data input, and drives the registered ready/busy pin.
// Assumes erase_sel describes the bank given by op_bank, and that
// DATA_W is at least 7 so that both toggle positions exist.
module flash_status_gen
    import flash_status_pkg::*;
#(
    parameter int NUM_BANKS    = 2,
    parameter int SECTORS      = 8,
    parameter int DATA_W       = 8,
    parameter int CLK_MHZ      = 100,
    parameter int ERASE_WIN_US = 100,
    parameter int PROG_WIN_US  = 1,
    localparam int BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int SEC_W       = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_state,
    input  logic [BANK_W-1:0] op_bank,
    input  logic [SECTORS-1:0] erase_sel,
    input  logic              op_start,
    input  logic              prot_hit,
    input  logic              rd_oe,
    input  logic              rd_ce,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [SEC_W-1:0]  rd_sector,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dout,
    output logic              rdy_bsy_n
);
    localparam int ERASE_CYC = ERASE_WIN_US * CLK_MHZ;
    localparam int PROG_CYC  = PROG_WIN_US * CLK_MHZ;
    localparam logic [DATA_W-1:0] TOG_MASK =
        (DATA_W'(1) << MAIN_TOG_BIT) | (DATA_W'(1) << SECT_TOG_BIT);

    op_mode_t          op_mode;
    op_mode_t          eff_mode;
    logic [BANK_W-1:0] eff_bank;
    logic              launch;
    logic              t_main, t_sect;
    logic              bank_hit, sel_hit, busy, ret_status;
    logic              flip_main, flip_sect;
    logic [DATA_W-1:0] status_byte;

    assign op_mode = op_mode_t'(op_state);

    fsg_read_launch u_launch (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_oe  (rd_oe),
        .rd_ce  (rd_ce),
        .launch (launch)
    );

    fsg_prot_window #(
        .BANK_W    (BANK_W),
        .ERASE_CYC (ERASE_CYC),
        .PROG_CYC  (PROG_CYC)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_mode  (op_mode),
        .op_bank  (op_bank),
        .op_start (op_start),
        .prot_hit (prot_hit),
        .eff_mode (eff_mode),
        .eff_bank (eff_bank)
    );

    // Classify the current read address against the effective operation.
    always_comb begin
        busy       = mode_is_busy(eff_mode);
        bank_hit   = (rd_bank == eff_bank) && (eff_mode != OP_IDLE);
        sel_hit    = erase_sel[rd_sector];
        ret_status = bank_hit && (busy || ((eff_mode == OP_SUSP) && sel_hit));
        flip_main  = launch && bank_hit && busy;
        flip_sect  = launch && bank_hit && mode_is_erase_family(eff_mode) && sel_hit;
    end

    fsg_toggle_bits u_toggles (
        .clk       (clk),
        .rst_n     (rst_n),
        .flip_main (flip_main),
        .flip_sect (flip_sect),
        .t_main    (t_main),
        .t_sect    (t_sect)
    );

    // Assemble the status byte from the toggle values before this read's flip.
    always_comb begin
        status_byte               = '0;
        status_byte[MAIN_TOG_BIT] = t_main;
        status_byte[SECT_TOG_BIT] = t_sect;
    end

    // Capture the returned value at each read launch.
    always_ff @(posedge clk) begin
        if (!rst_n)      dout <= '0;
        else if (launch) dout <= ret_status ? status_byte : rd_data;
    end

    // Register the ready/busy pin from the effective mode.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_bsy_n <= 1'b1;
        else        rdy_bsy_n <= ~busy;
    end

    p_busy_pin_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rdy_bsy_n);

    p_ready_pin_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> rdy_bsy_n);

    p_spare_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && ret_status) |=> ((dout & ~TOG_MASK) == '0));

    p_suspend_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && eff_mode == OP_SUSP) |=> $stable(t_main));

    p_array_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !ret_status) |=> (dout == $past(rd_data)));

    p_hold_output_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> $stable(dout));

endmodule

// File: tb/sim_flash_status_gen.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_flash_status_gen;

    localparam int NB = 2, NS = 8, DW = 8;
    localparam int EWIN = 40, PWIN = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_state = 3'd0;
    logic [0:0]    op_bank = '0;
    logic [NS-1:0] erase_sel = '0;
    logic          op_start = 1'b0, prot_hit = 1'b0;
    logic          rd_oe = 1'b0, rd_ce = 1'b0;
    logic [0:0]    rd_bank = '0;
    logic [2:0]    rd_sector = '0;
    logic [DW-1:0] rd_data = '0;
    logic [DW-1:0] dout;
    logic          rdy_bsy_n;

    int n_chk = 0, n_bad = 0;
    // bench model of the effective state
    int   m_mode = 0;
    logic m_bank = 1'b0;
    logic e6 = 1'b0, e2 = 1'b0;

    flash_status_gen #(
        .NUM_BANKS(NB), .SECTORS(NS), .DATA_W(DW),
        .CLK_MHZ(1), .ERASE_WIN_US(40), .PROG_WIN_US(6)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .op_state(op_state), .op_bank(op_bank),
        .erase_sel(erase_sel), .op_start(op_start), .prot_hit(prot_hit),
        .rd_oe(rd_oe), .rd_ce(rd_ce), .rd_bank(rd_bank), .rd_sector(rd_sector),
        .rd_data(rd_data), .dout(dout), .rdy_bsy_n(rdy_bsy_n)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // Expected read result from the requirements, updating the model toggles.
    function automatic logic [DW-1:0] model_read(logic bk, int sec, logic [DW-1:0] arr);
        logic hit, sel, busy, efam;
        logic [DW-1:0] r;
        busy = (m_mode == 1) || (m_mode == 2) || (m_mode == 4);
        efam = (m_mode == 2) || (m_mode == 3);
        hit  = (bk == m_bank) && (m_mode != 0);
        sel  = erase_sel[sec];
        if (hit && (busy || (m_mode == 3 && sel))) begin
            r = '0; r[6] = e6; r[2] = e2;
        end else r = arr;
        if (hit && busy) e6 = ~e6;
        if (hit && efam && sel) e2 = ~e2;
        return r;
    endfunction

    task automatic do_read(input string req, input logic bk, input int sec, input logic [DW-1:0] arr);
        logic [DW-1:0] exp;
        @(negedge clk);
        rd_bank = bk; rd_sector = 3'(sec); rd_data = arr;
        rd_oe = 1'b1; rd_ce = 1'b1;
        exp = model_read(bk, sec, arr);
        @(negedge clk);
        chk(req, dout, exp);
        rd_oe = 1'b0; rd_ce = 1'b0;
    endtask

    task automatic set_op(input int mode, input logic bk);
        @(negedge clk);
        op_state = 3'(mode); op_bank = bk; m_mode = mode; m_bank = bk;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R10 reset dout", dout, 8'h00);
        chk("R10 reset ready", {7'd0, rdy_bsy_n}, 8'h01);
    endtask

    task automatic t_idle;
        do_read("R6 idle read", 1'b0, 2, 8'hA5);
        do_read("R6 idle read bank1", 1'b1, 7, 8'h3C);
        chk("R1 idle ready", {7'd0, rdy_bsy_n}, 8'h01);
    endtask

    task automatic t_program;
        set_op(1, 1'b1);
        chk("R1 program busy", {7'd0, rdy_bsy_n}, 8'h00);
        do_read("R2 program read 1", 1'b1, 3, 8'hFF);
        do_read("R2 program read 2", 1'b1, 4, 8'hFF);
        do_read("R2 program read 3", 1'b1, 0, 8'h81);
        do_read("R6 other bank in program", 1'b0, 3, 8'h5A);
        set_op(0, 1'b1);
        chk("R1 ready after program", {7'd0, rdy_bsy_n}, 8'h01);
        do_read("R3 array after program", 1'b1, 3, 8'h77);
    endtask

    task automatic t_erase_suspend;
        erase_sel = 8'b0000_0110;
        set_op(2, 1'b0);
        chk("R1 erase busy", {7'd0, rdy_bsy_n}, 8'h00);
        do_read("R5 erase selected 1", 1'b0, 1, 8'h11);
        do_read("R5 erase selected 2", 1'b0, 2, 8'h12);
        do_read("R5 erase unselected", 1'b0, 5, 8'h15);
        set_op(3, 1'b0);
        chk("R1 suspend ready", {7'd0, rdy_bsy_n}, 8'h01);
        do_read("R3 suspend hold 1", 1'b0, 2, 8'h22);
        do_read("R3 suspend hold 2", 1'b0, 1, 8'h21);
        do_read("R6 suspend unselected", 1'b0, 5, 8'h25);
        set_op(4, 1'b0);
        chk("R1 suspend-program busy", {7'd0, rdy_bsy_n}, 8'h00);
        do_read("R4 suspend-program 1", 1'b0, 0, 8'h30);
        do_read("R4 suspend-program 2", 1'b0, 0, 8'h31);
        set_op(3, 1'b0);
        do_read("R3 suspend again", 1'b0, 1, 8'h41);
        set_op(0, 1'b0);
        erase_sel = '0;
    endtask

    task automatic t_strobes;
        logic [DW-1:0] exp;
        set_op(1, 1'b0);
        // chip enable first, then output enable, held for several cycles
        @(negedge clk); rd_bank = 1'b0; rd_sector = 3'd2; rd_ce = 1'b1;
        @(negedge clk); rd_oe = 1'b1; exp = model_read(1'b0, 2, 8'h00);
        repeat (4) @(negedge clk);
        chk("R9 ce-then-oe launch", dout, exp);
        rd_oe = 1'b0;
        @(negedge clk); rd_ce = 1'b0;
        // output enable first, then chip enable
        @(negedge clk); rd_oe = 1'b1;
        @(negedge clk); rd_ce = 1'b1; exp = model_read(1'b0, 2, 8'h00);
        repeat (3) @(negedge clk);
        chk("R9 oe-then-ce single toggle", dout, exp);
        rd_oe = 1'b0; rd_ce = 1'b0;
        // output held between launches
        rd_data = 8'hEE;
        repeat (3) @(negedge clk);
        chk("R10 dout held", dout, exp);
        set_op(0, 1'b0);
    endtask

    task automatic t_prot(input int mode, input int win, input string tag);
        @(negedge clk);
        op_state = 3'(mode); op_bank = 1'b1; op_start = 1'b1; prot_hit = 1'b1;
        m_mode = mode; m_bank = 1'b1;
        @(negedge clk);
        op_start = 1'b0; prot_hit = 1'b0;
        do_read({tag, " window read 1"}, 1'b1, 4, 8'h9C);
        chk({tag, " window busy"}, {7'd0, rdy_bsy_n}, 8'h00);
        do_read({tag, " window read 2"}, 1'b1, 6, 8'h9D);
        repeat (win + 2) @(negedge clk);
        m_mode = 0;
        do_read({tag, " array after window"}, 1'b1, 4, 8'h6B);
        chk({tag, " ready after window"}, {7'd0, rdy_bsy_n}, 8'h01);
        set_op(0, 1'b1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_idle;
        t_program;
        t_erase_suspend;
        t_strobes;
        t_prot(2, EWIN, "R7");
        t_prot(1, PWIN, "R8");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule